// File: doc/BRIEF.md
# Core-to-Router Network Interface with Source Steering

This block sits between a processor core and its mesh router and carries message-passing traffic in both directions. Words arriving from the router are sorted by their most significant bit into one of two receive queues. One queue holds words sent by other processor cores and feeds the extended register file or data memory. The other holds words sent by memory cores and feeds the receiver path. Keeping the two origins apart means a stalled consumer on one side does not block the other origin, which is what a single shared receive queue would do.

A third queue takes words the core sends and offers them to the router. Every queue is eight entries deep and shows full and empty flags. Every edge uses a valid/ready handshake. When the queue a word is aimed at cannot take it, ready to the router drops, so the word stays on the router side and is not lost. The tag bit stays in the stored word, so consumers can still read it.

Top module: `core_net_iface`

## Requirements
- R1: After reset all three queues are empty: every output valid is 0, every empty flag is 1 and every full flag is 0.
- R2: An accepted router word with bit 31 equal to 0 (processor origin) enters the processor-origin queue only, and leaves on `pc_data_o` in arrival order.
- R3: An accepted router word with bit 31 equal to 1 (memory origin) enters the memory-origin queue only, and leaves on `mc_data_o` in arrival order.
- R4: Each queue delivers the whole 32-bit word unchanged, bit 31 included.
- R5: `rx_ready_o` is 0 when the queue chosen by bit 31 of `rx_data_i` holds 8 words and its consumer is not taking one in that cycle. The offered word is then neither stored nor lost.
- R6: A queue holding 8 words accepts a push in the same cycle as a pop, and stays at 8 words.
- R7: A word pushed into an empty queue appears on that queue's output in the next cycle, not in the cycle it is pushed.
- R8: Words the core offers on `tx_*` reach `net_data_o` in order. `tx_ready_o` is 0 only when the transmit queue holds 8 words and `net_ready_i` is 0.
- R9: Each full flag is 1 exactly when its queue holds 8 words. Each empty flag is 1 exactly when its queue holds none.
- R10: A full processor-origin queue does not block memory-origin words, and a full memory-origin queue does not block processor-origin words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Router offers a word |
| rx_data_i | input | 32 | Router word; bit 31 gives its origin |
| rx_ready_o | output | 1 | Targeted queue can take the word |
| pc_valid_o | output | 1 | Processor-origin word available |
| pc_data_o | output | 32 | Head of processor-origin queue |
| pc_ready_i | input | 1 | Register-file side takes the word |
| mc_valid_o | output | 1 | Memory-origin word available |
| mc_data_o | output | 32 | Head of memory-origin queue |
| mc_ready_i | input | 1 | Receiver side takes the word |
| tx_valid_i | input | 1 | Core offers an outgoing word |
| tx_data_i | input | 32 | Outgoing word |
| tx_ready_o | output | 1 | Transmit queue can take the word |
| net_valid_o | output | 1 | Outgoing word available to router |
| net_data_o | output | 32 | Head of transmit queue |
| net_ready_i | input | 1 | Router takes the outgoing word |
| pc_full_o | output | 1 | Processor-origin queue holds 8 words |
| pc_empty_o | output | 1 | Processor-origin queue is empty |
| mc_full_o | output | 1 | Memory-origin queue holds 8 words |
| mc_empty_o | output | 1 | Memory-origin queue is empty |
| tx_full_o | output | 1 | Transmit queue holds 8 words |
| tx_empty_o | output | 1 | Transmit queue is empty |

## Verification
The ready outputs are combinational. They are due in the same cycle as the inputs they depend on, so the bench compares them a short delay after driving inputs and before the next rising edge. Queue contents, valid outputs, data and flags change one edge after a handshake, so a word pushed at an edge is first expected at the following compare point. That is what R7 asks for. The bench model updates its queues at each edge from the handshakes it predicted. Phases with stalled consumers fill the queues, so that the full-queue, push-with-pop and cross-blocking cases occur often.

// File: rtl/core_net_iface_pkg.sv
package core_net_iface_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned Q_DEPTH = 8;

  typedef enum logic {
    ORIGIN_CORE = 1'b0,
    ORIGIN_MEM  = 1'b1
  } origin_e;

  // queue slots inside the top
  localparam int unsigned Q_PC = 0;
  localparam int unsigned Q_MC = 1;
  localparam int unsigned Q_TX = 2;
  localparam int unsigned N_Q  = 3;
endpackage

// File: rtl/nif_fifo.sv
module nif_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_valid_i,
  input  logic [W-1:0] push_data_i,
  output logic         push_ready_o,
  output logic         pop_valid_o,
  output logic [W-1:0] pop_data_o,
  input  logic         pop_ready_i,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_fire, pop_fire;

  assign full_o       = (cnt_q == FULL_CNT);
  assign empty_o      = (cnt_q == '0);
  assign pop_valid_o  = !empty_o;
  assign pop_data_o   = mem_q[rd_ptr_q];
  // a pop on full frees the slot for this cycle's push
  assign push_ready_o = !full_o || pop_ready_i;
  assign push_fire    = push_valid_i && push_ready_o;
  assign pop_fire     = pop_valid_o && pop_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_fire) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop_fire)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      if (push_fire && !pop_fire)      cnt_q <= cnt_q + 1'b1;
      else if (pop_fire && !push_fire) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_fire) mem_q[wr_ptr_q] <= push_data_i;
  end

  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_fire) |-> pop_fire);
  a_r9_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
  a_r7_empty_push_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && push_fire) |=> (pop_valid_o && $past(push_data_i) == pop_data_o));
  a_r6_full_swap_stays_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_fire && pop_fire) |=> full_o);
endmodule

// File: rtl/nif_steer.sv
module nif_steer
  import core_net_iface_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         rx_valid_i,
  input  logic [W-1:0] rx_data_i,
  output logic         rx_ready_o,
  input  logic         pc_room_i,
  input  logic         mc_room_i,
  output logic         pc_push_o,
  output logic         mc_push_o
);
  origin_e origin;

  assign origin     = origin_e'(rx_data_i[W-1]);
  assign rx_ready_o = (origin == ORIGIN_MEM) ? mc_room_i : pc_room_i;
  assign pc_push_o  = rx_valid_i && (origin == ORIGIN_CORE);
  assign mc_push_o  = rx_valid_i && (origin == ORIGIN_MEM);
endmodule

// File: rtl/core_net_iface.sv
module core_net_iface
  import core_net_iface_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [WORD_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  output logic              pc_valid_o,
  output logic [WORD_W-1:0] pc_data_o,
  input  logic              pc_ready_i,
  output logic              mc_valid_o,
  output logic [WORD_W-1:0] mc_data_o,
  input  logic              mc_ready_i,
  input  logic              tx_valid_i,
  input  logic [WORD_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic              net_valid_o,
  output logic [WORD_W-1:0] net_data_o,
  input  logic              net_ready_i,
  output logic              pc_full_o,
  output logic              pc_empty_o,
  output logic              mc_full_o,
  output logic              mc_empty_o,
  output logic              tx_full_o,
  output logic              tx_empty_o
);
  logic [N_Q-1:0]    q_push_valid, q_push_ready, q_pop_valid, q_pop_ready, q_full, q_empty;
  logic [WORD_W-1:0] q_push_data [N_Q];
  logic [WORD_W-1:0] q_pop_data  [N_Q];
  logic              pc_push, mc_push;

  nif_steer #(.W(WORD_W)) u_steer (
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .rx_ready_o (rx_ready_o),
    .pc_room_i  (q_push_ready[Q_PC]),
    .mc_room_i  (q_push_ready[Q_MC]),
    .pc_push_o  (pc_push),
    .mc_push_o  (mc_push)
  );

  assign q_push_valid[Q_PC] = pc_push;
  assign q_push_valid[Q_MC] = mc_push;
  assign q_push_valid[Q_TX] = tx_valid_i;
  assign q_push_data[Q_PC]  = rx_data_i;
  assign q_push_data[Q_MC]  = rx_data_i;
  assign q_push_data[Q_TX]  = tx_data_i;
  assign q_pop_ready[Q_PC]  = pc_ready_i;
  assign q_pop_ready[Q_MC]  = mc_ready_i;
  assign q_pop_ready[Q_TX]  = net_ready_i;

  for (genvar g = 0; g < N_Q; g++) begin : g_q
    nif_fifo #(.W(WORD_W), .DEPTH(Q_DEPTH)) u_fifo (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .push_valid_i (q_push_valid[g]),
      .push_data_i  (q_push_data[g]),
      .push_ready_o (q_push_ready[g]),
      .pop_valid_o  (q_pop_valid[g]),
      .pop_data_o   (q_pop_data[g]),
      .pop_ready_i  (q_pop_ready[g]),
      .full_o       (q_full[g]),
      .empty_o      (q_empty[g])
    );
  end

  assign tx_ready_o  = q_push_ready[Q_TX];
  assign pc_valid_o  = q_pop_valid[Q_PC];
  assign pc_data_o   = q_pop_data[Q_PC];
  assign mc_valid_o  = q_pop_valid[Q_MC];
  assign mc_data_o   = q_pop_data[Q_MC];
  assign net_valid_o = q_pop_valid[Q_TX];
  assign net_data_o  = q_pop_data[Q_TX];
  assign pc_full_o   = q_full[Q_PC];
  assign pc_empty_o  = q_empty[Q_PC];
  assign mc_full_o   = q_full[Q_MC];
  assign mc_empty_o  = q_empty[Q_MC];
  assign tx_full_o   = q_full[Q_TX];
  assign tx_empty_o  = q_empty[Q_TX];

  a_r5_accept_has_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_ready_o) |-> (rx_data_i[WORD_W-1] ? q_push_ready[Q_MC] : q_push_ready[Q_PC]));
  a_r2_r3_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pc_push, mc_push}));
  a_r10_mem_word_ignores_pc_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_data_i[WORD_W-1] && pc_full_o && !mc_full_o) |-> rx_ready_o);
  a_r1_reset_empty: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (pc_empty_o && mc_empty_o && tx_empty_o));
endmodule

// File: tb/tb_core_net_iface.sv
`timescale 1ns/1ps
module tb_core_net_iface;
  localparam int DEPTH = 8;
  localparam int NCYC  = 3000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_valid_i = 1'b0, pc_ready_i = 1'b0, mc_ready_i = 1'b0;
  logic        tx_valid_i = 1'b0, net_ready_i = 1'b0;
  logic [31:0] rx_data_i = '0, tx_data_i = '0;
  logic        rx_ready_o, tx_ready_o, pc_valid_o, mc_valid_o, net_valid_o;
  logic [31:0] pc_data_o, mc_data_o, net_data_o;
  logic        pc_full_o, pc_empty_o, mc_full_o, mc_empty_o, tx_full_o, tx_empty_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] q_pc[$];
  logic [31:0] q_mc[$];
  logic [31:0] q_tx[$];
  bit pc_was_empty = 1, mc_was_empty = 1;

  always #2.5 clk_i = ~clk_i;

  core_net_iface dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  function automatic bit room(input int sz, input bit rdy);
    return (sz < DEPTH) || rdy;
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #1;
    // R1: reset state
    chk("R1 pc_valid", 32'(pc_valid_o), 0);
    chk("R1 mc_valid", 32'(mc_valid_o), 0);
    chk("R1 net_valid", 32'(net_valid_o), 0);
    chk("R1 empty flags", 32'({pc_empty_o, mc_empty_o, tx_empty_o}), 32'h7);
    chk("R1 full flags", 32'({pc_full_o, mc_full_o, tx_full_o}), 0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      int pr;
      bit exp_rx_rdy, exp_tx_rdy, msb;
      @(negedge clk_i);
      // drive
      if (c < 500) pr = 10;
      else if (c < 1000) pr = -1;  // pc stalled, mc free-running
      else if (c < 1500) pr = -2;  // mc stalled, pc free-running
      else pr = 50;
      rx_valid_i  = ($urandom_range(99) < 70);
      rx_data_i   = $urandom();
      tx_valid_i  = ($urandom_range(99) < 60);
      tx_data_i   = $urandom();
      if (pr == -1) begin pc_ready_i = 0; mc_ready_i = 1; end
      else if (pr == -2) begin pc_ready_i = 1; mc_ready_i = 0; end
      else begin
        pc_ready_i = ($urandom_range(99) < pr);
        mc_ready_i = ($urandom_range(99) < pr);
      end
      net_ready_i = ($urandom_range(99) < ((pr > 0) ? pr : 40));
      #1;
      // compare outputs against model
      msb = rx_data_i[31];
      exp_rx_rdy = msb ? room(q_mc.size(), mc_ready_i) : room(q_pc.size(), pc_ready_i);
      exp_tx_rdy = room(q_tx.size(), net_ready_i);
      if (msb && q_pc.size() == DEPTH && !pc_ready_i)
        chk("R10 mem word past full pc queue", 32'(rx_ready_o), 32'(exp_rx_rdy));
      else if (!msb && q_mc.size() == DEPTH && !mc_ready_i)
        chk("R10 core word past full mc queue", 32'(rx_ready_o), 32'(exp_rx_rdy));
      else if ((msb ? q_mc.size() : q_pc.size()) == DEPTH &&
               (msb ? mc_ready_i : pc_ready_i))
        chk("R6 push with pop on full", 32'(rx_ready_o), 32'(exp_rx_rdy));
      else
        chk("R5 rx_ready", 32'(rx_ready_o), 32'(exp_rx_rdy));
      chk("R8 tx_ready", 32'(tx_ready_o), 32'(exp_tx_rdy));
      chk(pc_was_empty ? "R7 pc_valid after empty" : "R2 pc_valid",
          32'(pc_valid_o), 32'(q_pc.size() > 0));
      chk(mc_was_empty ? "R7 mc_valid after empty" : "R3 mc_valid",
          32'(mc_valid_o), 32'(q_mc.size() > 0));
      chk("R8 net_valid", 32'(net_valid_o), 32'(q_tx.size() > 0));
      if (q_pc.size() > 0) chk("R2 R4 pc_data", pc_data_o, q_pc[0]);
      if (q_mc.size() > 0) chk("R3 R4 mc_data", mc_data_o, q_mc[0]);
      if (q_tx.size() > 0) chk("R8 net_data", net_data_o, q_tx[0]);
      chk("R9 full flags", 32'({pc_full_o, mc_full_o, tx_full_o}),
          32'({q_pc.size() == DEPTH, q_mc.size() == DEPTH, q_tx.size() == DEPTH}));
      chk("R9 empty flags", 32'({pc_empty_o, mc_empty_o, tx_empty_o}),
          32'({q_pc.size() == 0, q_mc.size() == 0, q_tx.size() == 0}));
      // model update at the coming edge
      pc_was_empty = (q_pc.size() == 0);
      mc_was_empty = (q_mc.size() == 0);
      begin
        bit pop_pc, pop_mc, pop_tx;
        pop_pc = (q_pc.size() > 0) && pc_ready_i;
        pop_mc = (q_mc.size() > 0) && mc_ready_i;
        pop_tx = (q_tx.size() > 0) && net_ready_i;
        @(posedge clk_i);
        if (pop_pc) void'(q_pc.pop_front());
        if (pop_mc) void'(q_mc.pop_front());
        if (pop_tx) void'(q_tx.pop_front());
        if (rx_valid_i && exp_rx_rdy) begin
          if (msb) q_mc.push_back(rx_data_i);
          else     q_pc.push_back(rx_data_i);
        end
        if (tx_valid_i && exp_tx_rdy) q_tx.push_back(tx_data_i);
      end
    end
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #900us;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule